// File: doc/BRIEF.md
# Memory-Mapped Character LCD Bridge

This block is glue logic between the external memory bus of an 8-bit microcontroller and a parallel character LCD module. It only writes to the display. The bus is multiplexed. One byte lane first carries the low address and later the data. A second byte lane carries the high address. The bus also has an address-latch strobe, an active-low write strobe and an active-low read strobe. The block runs on a fast system clock and brings every bus input into that clock domain before it uses it.

Firmware drives the display one pin at a time by storing bytes to fixed external addresses. A store to one high-address page sets the register-select pin. A store to a second page sets the enable pin. A store to a third page loads the byte that drives the display data lines. To make an enable pulse, firmware stores 1 and then 0 to the enable page. The data lines hold their value between stores, so the display sees valid data for the whole pulse. An optional filter on the latched low address can narrow each page down to one location.

Top module: `lcd_bus_bridge`

## Requirements
- R1: After a synchronous reset, `lcd_e`, `lcd_rs` and `lcd_rw` are 0 and `lcd_db` is 0x00.
- R2: The low address byte is captured from `bus_ad` while `bus_ale` is high. A write is accepted only if `(lo ^ LO_MATCH) & LO_MASK` is zero. With the default `LO_MASK` of 0x00, every low address is accepted.
- R3: An accepted write with high byte 0xF0 copies data bit 0 into `lcd_rs`: 0 selects the instruction register and 1 selects the data register. Data bits 7..1 are ignored.
- R4: An accepted write with high byte 0xF1 copies data bit 0 into `lcd_e`. Data bits 7..1 are ignored.
- R5: An accepted write with high byte 0xF3 loads the whole data byte into `lcd_db`. `lcd_db` keeps that value until the next accepted write to 0xF3, whatever else happens on the bus.
- R6: `lcd_rw` is 0 at all times.
- R7: A write to any other high byte leaves `lcd_e`, `lcd_rs` and `lcd_db` unchanged.
- R8: An update happens on the rising edge of the synchronized write strobe, once per bus cycle. It becomes visible within SYNC_STAGES+2 clocks of that edge. While the strobe is still low, no output changes.
- R9: Read cycles change no output. If the write strobe rises while the read strobe is still low, that write is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ad | input | 8 | Multiplexed low-address / data lane |
| bus_ahi | input | 8 | High address byte |
| bus_ale | input | 1 | Address latch enable, active high |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| lcd_e | output | 1 | LCD enable pin |
| lcd_rs | output | 1 | LCD register select (0 instruction, 1 data) |
| lcd_rw | output | 1 | LCD read/write pin, held at write (0) |
| lcd_db | output | 8 | LCD data lines |

## Verification
The bench builds two instances that share the same bus wires.

- One instance uses the default parameters: two synchronizer stages and no low-address filter. It exercises page decoding, single-bit updates and the holding of the data lines.
- The other instance sets `LO_MASK` to 0xFF and `LO_MATCH` to 0x5A. Writes whose low address does not match must then leave it untouched while the first instance updates. This makes the captured low address observable at the ports.

// File: rtl/lcdb_pkg.sv
// Package: shared types and constants for the LCD bus bridge.
// Assumes an 8-bit multiplexed bus and a 3-bit LCD control group.
package lcdb_pkg;
    localparam int BYTE_W = 8;

    // Bit positions inside the control group; the output ports decode these.
    localparam int CTL_RW = 0;
    localparam int CTL_E  = 1;
    localparam int CTL_RS = 2;
    localparam int CTL_W  = 3;

    // One completed bus write as seen after synchronization.
    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] data;
    } bus_wr_t;

    // Register targeted by a write.
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_RS   = 2'd1,
        TGT_EN   = 2'd2,
        TGT_DB   = 2'd3
    } tgt_e;
endpackage

// File: rtl/lcdb_sync.sv
// Module: multi-flop synchronizer for a vector of slow bus inputs.
// Assumes STAGES >= 2 and that all bits are stable across several clocks,
// so bits that travel together arrive together.
module lcdb_sync #(
    parameter int               WIDTH     = 8,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift the inputs through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RESET_VAL;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lcdb_capture.sv
// Module: reconstructs bus write cycles from synchronized strobes.
// Latches the low address during ALE. Samples the high address and data
// while the write strobe is low. Pulses commit for one clock when the
// write strobe rises and the read strobe is idle.
module lcdb_capture
    import lcdb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale_s,
    input  logic              wr_n_s,
    input  logic              rd_n_s,
    input  logic [BYTE_W-1:0] ad_s,
    input  logic [BYTE_W-1:0] ahi_s,
    output bus_wr_t           cyc,
    output logic              commit
);
    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] hi_q;
    logic [BYTE_W-1:0] data_q;
    logic              wr_n_d;

    // Capture the low address while the lane carries it.
    always_ff @(posedge clk) begin
        if (!rst_n)     lo_q <= '0;
        else if (ale_s) lo_q <= ad_s;
    end

    // Track the high address and data during the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            data_q <= '0;
        end else if (!wr_n_s) begin
            hi_q   <= ahi_s;
            data_q <= ad_s;
        end
    end

    // Delay the strobe by one clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_n_d <= 1'b1;
        else        wr_n_d <= wr_n_s;
    end

    assign commit   = wr_n_s & ~wr_n_d & rd_n_s;
    assign cyc.hi   = hi_q;
    assign cyc.lo   = lo_q;
    assign cyc.data = data_q;

    // R8: a commit never repeats on the following clock.
    p_single_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // R8: a commit is always preceded by a low strobe.
    p_commit_after_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(!wr_n_s));

    // R2: the low address is held outside the ALE phase.
    p_lo_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ale_s |=> $stable(cyc.lo));
endmodule

// File: rtl/lcdb_regs.sv
// Module: decodes committed writes and holds the LCD pin registers.
// Assumes commit lasts one clock per bus cycle. R/W is held at write.
module lcdb_regs
    import lcdb_pkg::*;
#(
    parameter logic [BYTE_W-1:0] HI_RS    = 8'hF0,
    parameter logic [BYTE_W-1:0] HI_EN    = 8'hF1,
    parameter logic [BYTE_W-1:0] HI_DB    = 8'hF3,
    parameter logic [BYTE_W-1:0] LO_MASK  = 8'h00,
    parameter logic [BYTE_W-1:0] LO_MATCH = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  bus_wr_t           cyc,
    output logic              lcd_e,
    output logic              lcd_rs,
    output logic              lcd_rw,
    output logic [BYTE_W-1:0] lcd_db
);
    logic [CTL_W-1:0]  ctrl_q;
    logic [BYTE_W-1:0] db_q;
    logic              lo_ok;
    tgt_e              tgt;

    // Select the target register from the high byte and the low filter.
    always_comb begin
        lo_ok = (((cyc.lo ^ LO_MATCH) & LO_MASK) == '0);
        tgt   = TGT_NONE;
        if (lo_ok) begin
            if (cyc.hi == HI_RS)      tgt = TGT_RS;
            else if (cyc.hi == HI_EN) tgt = TGT_EN;
            else if (cyc.hi == HI_DB) tgt = TGT_DB;
        end
    end

    // Update the control group bit by bit; R/W stays at write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q[CTL_RW] <= 1'b0;
            if (commit && tgt == TGT_RS) ctrl_q[CTL_RS] <= cyc.data[0];
            if (commit && tgt == TGT_EN) ctrl_q[CTL_E]  <= cyc.data[0];
        end
    end

    // Load the data lines; hold them between data-page writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                       db_q <= '0;
        else if (commit && tgt == TGT_DB) db_q <= cyc.data;
    end

    assign lcd_rw = ctrl_q[CTL_RW];
    assign lcd_e  = ctrl_q[CTL_E];
    assign lcd_rs = ctrl_q[CTL_RS];
    assign lcd_db = db_q;

    // R3: the select pin follows data bit 0 of a select-page write.
    p_rs_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && lo_ok && cyc.hi == HI_RS) |=> lcd_rs == $past(cyc.data[0]));

    // R4: the enable pin follows data bit 0 of an enable-page write.
    p_en_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && lo_ok && cyc.hi == HI_EN) |=> lcd_e == $past(cyc.data[0]));

    // R5: the data lines take the full byte of a data-page write.
    p_db_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && lo_ok && cyc.hi == HI_DB) |=> lcd_db == $past(cyc.data));

    // R7: a write to an undecoded page changes nothing.
    p_undecoded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && cyc.hi != HI_RS && cyc.hi != HI_EN && cyc.hi != HI_DB)
        |=> $stable({lcd_e, lcd_rs, lcd_db}));

    // R8: without a commit, every pin holds.
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable({lcd_e, lcd_rs, lcd_db}));

    // R6: the read/write pin never leaves write.
    p_rw_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !lcd_rw);
endmodule

// File: rtl/lcd_bus_bridge.sv
// Module: top of the memory-mapped LCD bridge.
// Synchronizes the multiplexed bus, rebuilds write cycles and drives the
// LCD pins. Assumes bus signals are stable for several system clocks.
module lcd_bus_bridge
    import lcdb_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] HI_RS       = 8'hF0,
    parameter logic [BYTE_W-1:0] HI_EN       = 8'hF1,
    parameter logic [BYTE_W-1:0] HI_DB       = 8'hF3,
    parameter logic [BYTE_W-1:0] LO_MASK     = 8'h00,
    parameter logic [BYTE_W-1:0] LO_MATCH    = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] bus_ad,
    input  logic [BYTE_W-1:0] bus_ahi,
    input  logic              bus_ale,
    input  logic              bus_wr_n,
    input  logic              bus_rd_n,
    output logic              lcd_e,
    output logic              lcd_rs,
    output logic              lcd_rw,
    output logic [BYTE_W-1:0] lcd_db
);
    localparam int               SYNC_W   = 3 + 2 * BYTE_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {1'b0, 1'b1, 1'b1, {(2*BYTE_W){1'b0}}};

    logic [SYNC_W-1:0] raw_bus;
    logic [SYNC_W-1:0] sync_bus;
    logic              ale_s;
    logic              wr_n_s;
    logic              rd_n_s;
    logic [BYTE_W-1:0] ahi_s;
    logic [BYTE_W-1:0] ad_s;
    bus_wr_t           cyc;
    logic              commit;

    assign raw_bus = {bus_ale, bus_wr_n, bus_rd_n, bus_ahi, bus_ad};
    assign {ale_s, wr_n_s, rd_n_s, ahi_s, ad_s} = sync_bus;

    lcdb_sync #(
        .WIDTH    (SYNC_W),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(SYNC_RST)
    ) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_bus),
        .q    (sync_bus)
    );

    lcdb_capture capture_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ale_s (ale_s),
        .wr_n_s(wr_n_s),
        .rd_n_s(rd_n_s),
        .ad_s  (ad_s),
        .ahi_s (ahi_s),
        .cyc   (cyc),
        .commit(commit)
    );

    lcdb_regs #(
        .HI_RS   (HI_RS),
        .HI_EN   (HI_EN),
        .HI_DB   (HI_DB),
        .LO_MASK (LO_MASK),
        .LO_MATCH(LO_MATCH)
    ) regs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .commit(commit),
        .cyc   (cyc),
        .lcd_e (lcd_e),
        .lcd_rs(lcd_rs),
        .lcd_rw(lcd_rw),
        .lcd_db(lcd_db)
    );

    // R9: a write strobe rising during a read commits nothing.
    p_rd_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n_s && $rose(wr_n_s)) |=> $stable({lcd_e, lcd_rs, lcd_db}));
endmodule

// File: tb/lcd_bus_bridge_tb.sv
`timescale 1ns/1ps
module lcd_bus_bridge_tb_top;
    localparam logic [7:0] LO_SEL = 8'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_ad = 8'h00;
    logic [7:0] bus_ahi = 8'h00;
    logic       bus_ale = 1'b0;
    logic       bus_wr_n = 1'b1;
    logic       bus_rd_n = 1'b1;

    logic       e0, rs0, rw0, e1, rs1, rw1;
    logic [7:0] db0, db1;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference state per instance: 0 default, 1 low-address filtered.
    logic       m_rs [2];
    logic       m_e  [2];
    logic [7:0] m_db [2];

    always #4 clk = ~clk;

    lcd_bus_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .bus_ad(bus_ad), .bus_ahi(bus_ahi),
        .bus_ale(bus_ale), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n),
        .lcd_e(e0), .lcd_rs(rs0), .lcd_rw(rw0), .lcd_db(db0)
    );

    lcd_bus_bridge #(.LO_MASK(8'hFF), .LO_MATCH(LO_SEL)) dut_lo_i (
        .clk(clk), .rst_n(rst_n), .bus_ad(bus_ad), .bus_ahi(bus_ahi),
        .bus_ale(bus_ale), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n),
        .lcd_e(e1), .lcd_rs(rs1), .lcd_rw(rw1), .lcd_db(db1)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [10:0] act, input logic [10:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h (rw,rs,e,db)", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, {rw0, rs0, e0, db0}, {1'b0, m_rs[0], m_e[0], m_db[0]});
        chk(req, {rw1, rs1, e1, db1}, {1'b0, m_rs[1], m_e[1], m_db[1]});
    endtask

    // Expected effect of one accepted write on both instances.
    task automatic model_apply(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] dat);
        for (int k = 0; k < 2; k++) begin
            if (k == 0 || lo == LO_SEL) begin
                case (hi)
                    8'hF0:   m_rs[k] = dat[0];
                    8'hF1:   m_e[k]  = dat[0];
                    8'hF3:   m_db[k] = dat;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic bus_write(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] dat,
                             input bit rd_clash, input bit mid_check);
        bus_ahi = hi; bus_ad = lo; bus_ale = 1'b1;
        tick(3);
        bus_ale = 1'b0;
        tick(1);
        bus_ad = dat; bus_wr_n = 1'b0;
        if (rd_clash) bus_rd_n = 1'b0;
        tick(5);
        if (mid_check) check_all("R8");  // strobe still low: nothing moved
        bus_wr_n = 1'b1;
        tick(6);
        bus_rd_n = 1'b1; bus_ad = 8'($urandom);
        tick(2);
        if (!rd_clash) model_apply(hi, lo, dat);
    endtask

    task automatic bus_read(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] drive);
        bus_ahi = hi; bus_ad = lo; bus_ale = 1'b1;
        tick(3);
        bus_ale = 1'b0;
        tick(1);
        bus_rd_n = 1'b0; bus_ad = drive;
        tick(5);
        bus_rd_n = 1'b1;
        tick(6);
    endtask

    function automatic string tag_for(input logic [7:0] hi);
        case (hi)
            8'hF0:   return "R3";
            8'hF1:   return "R4";
            8'hF3:   return "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k < 2; k++) begin
            m_rs[k] = 1'b0; m_e[k] = 1'b0; m_db[k] = 8'h00;
        end
        tick(4);
        check_all("R1");  // held in reset
        rst_n = 1'b1;
        tick(3);
        check_all("R1");  // state right after reset

        // R5 and R8: data page, checked mid-strobe and after release.
        bus_write(8'hF3, LO_SEL, 8'h3F, 1'b0, 1'b1);
        check_all("R5");
        // R3: select page uses bit 0 only.
        bus_write(8'hF0, LO_SEL, 8'h01, 1'b0, 1'b1);
        check_all("R3");
        bus_write(8'hF0, LO_SEL, 8'hFE, 1'b0, 1'b0);
        check_all("R3");
        bus_write(8'hF0, LO_SEL, 8'h81, 1'b0, 1'b0);
        check_all("R3");
        // R4: enable pulse, high then low; data lines must hold (R5).
        bus_write(8'hF1, LO_SEL, 8'h01, 1'b0, 1'b1);
        check_all("R4");
        bus_write(8'hF1, LO_SEL, 8'hF0, 1'b0, 1'b0);
        check_all("R4");
        check_all("R5");
        // R7: undecoded page with all ones.
        bus_write(8'hF2, LO_SEL, 8'hFF, 1'b0, 1'b0);
        check_all("R7");
        bus_write(8'h00, LO_SEL, 8'hFF, 1'b0, 1'b0);
        check_all("R7");
        // R2: mismatching low address moves only the unfiltered instance.
        bus_write(8'hF3, 8'h00, 8'hC3, 1'b0, 1'b0);
        check_all("R2");
        bus_write(8'hF1, 8'hA5, 8'h01, 1'b0, 1'b0);
        check_all("R2");
        // R9: a read cycle and a write overlapped by a read change nothing.
        bus_read(8'hF3, LO_SEL, 8'hAA);
        check_all("R9");
        bus_write(8'hF3, LO_SEL, 8'h55, 1'b1, 1'b0);
        check_all("R9");

        // Random mix of pages, data and low addresses.
        for (int i = 0; i < 400; i++) begin
            int unsigned sel;
            logic [7:0] hi, lo, dat;
            sel = $urandom_range(0, 6);
            lo  = ($urandom_range(0, 1) == 1) ? LO_SEL : 8'($urandom);
            dat = 8'($urandom);
            case (sel)
                0, 1:    hi = 8'hF3;
                2:       hi = 8'hF0;
                3:       hi = 8'hF1;
                default: hi = 8'($urandom);
            endcase
            if (sel == 6) begin
                bus_read(hi, lo, dat);
                check_all("R9");
            end else begin
                bus_write(hi, lo, dat, 1'b0, (i % 16) == 0);
                check_all(tag_for(hi));
            end
        end
        check_all("R6");  // read/write pin still at write

        done = 1'b1;
        finish_run();
    end
endmodule